// File: doc/BRIEF.md
# SMBus Protocol Transaction Dispatcher

The dispatcher sits between the host register front end of an SMBus controller and a byte-level bus engine. A start pulse makes it capture a snapshot of the control protocol field, the address byte, the command byte and the two data bytes. It then runs the matching list of byte operations on the engine: address start, byte send, byte receive with ACK, byte receive with NACK, and stop. Each operation is handed over on a valid/acknowledge pair. The engine answers each operation with an error flag and, for receives, a data byte.

Received bytes go to two result registers, or to a block byte register when the protocol is the I2C-style block read. When the run ends, the block gives exactly one result pulse, together with a `done` pulse. The result is one of: interrupt-worthy success, device error, hand-off to the block buffering engine, or first block byte ready. Block buffering is not part of this block. Protocol 5 only raises the hand-off pulse.

Top module: `smbus_xact_dispatch`

## Requirements
- R1: After reset, `busy`, `op_valid` and every result pulse are low, and `rd_data0`, `rd_data1` and `blk_byte` are 0.
- R2: Operation codes on `op_code` are 0 address start, 1 send, 2 receive-with-ACK, 3 receive-with-NACK and 4 stop. A start operation carries the 7-bit target (`addr_in[7:1]`) in `op_byte[7:1]` and the direction in `op_byte[0]`, where 1 means read. A send carries its data byte. Receives and stops carry 0.
- R3: Protocol 0 (`ctl_proto`) issues a start with `op_byte` equal to `addr_in`, including its bit 0, then a stop. It then pulses `intr_set`.
- R4: Protocol 1 with `addr_in[0]`=0 issues a write start, a send of `cmd_in` and a stop. With `addr_in[0]`=1 it issues a read start, a NACK receive into `rd_data0` and a stop. Both end with `intr_set`.
- R5: Protocol 2 write issues a write start, a send of `cmd_in`, a send of `data0_in` and a stop. Protocol 2 read issues a write start, a send of `cmd_in`, a read start, a NACK receive into `rd_data0` and a stop. Both end with `intr_set`.
- R6: Protocol 3 write sends `cmd_in`, then `data0_in` as the low byte, then `data1_in` as the high byte. Protocol 3 read sends `cmd_in`, then after a read start does an ACK receive into `rd_data0` (low byte) and a NACK receive into `rd_data1` (high byte). Both end with a stop and `intr_set`.
- R7: Protocol 6 ignores `addr_in[0]`. It issues a write start, a send of `data1_in`, a read start and an ACK receive into `blk_byte`, with no stop. It ends with `blkrd_ready` and no `intr_set`.
- R8: Protocol codes 4 and 7 issue no bus operation and pulse `dev_err_set` the cycle after the start is accepted.
- R9: An operation acknowledged with `op_err`=1 ends the transaction. No further operation is issued, `dev_err_set` pulses and `intr_set` does not.
- R10: A start while `err_sticky` is 1 issues no bus operation and pulses `dev_err_set` the cycle after acceptance, whatever the protocol.
- R11: Protocol 5 issues no bus operation and pulses `blk_go` the cycle after acceptance, with no `intr_set`.
- R12: A start while `busy` is 1 is ignored. The running sequence and its results are unchanged, and no second transaction follows.
- R13: While `op_valid` is 1 and `op_ack` is 0, `op_code` and `op_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Transaction start pulse |
| ctl_proto | input | 3 | Protocol code |
| addr_in | input | 8 | Target address in [7:1], read flag in [0] |
| cmd_in | input | 8 | Command byte |
| data0_in | input | 8 | Data byte 0 (word low byte) |
| data1_in | input | 8 | Data byte 1 (word high byte, block-read command) |
| err_sticky | input | 1 | Device-error status already set |
| op_valid | output | 1 | Bus operation request |
| op_code | output | 3 | Bus operation code |
| op_byte | output | 8 | Bus operation byte |
| op_ack | input | 1 | Engine finished the operation |
| op_err | input | 1 | Operation failed (valid with op_ack) |
| op_rdata | input | 8 | Received byte (valid with op_ack) |
| busy | output | 1 | Bus sequence in progress |
| done | output | 1 | Transaction ended (one cycle) |
| intr_set | output | 1 | Successful non-block transaction |
| dev_err_set | output | 1 | Device error |
| blk_go | output | 1 | Block data hand-off |
| blkrd_ready | output | 1 | First block-read byte received |
| rd_data0 | output | 8 | Result byte 0 |
| rd_data1 | output | 8 | Result byte 1 |
| blk_byte | output | 8 | Received block byte |

## Verification
A start accepted at an edge makes `op_valid` visible right after that edge. Each operation advances at the edge where `op_ack` is sampled. The result pulses and `done` are registered, so they appear one cycle after the deciding edge: the acceptance edge for refused or handed-off starts, and the final acknowledge edge for bus runs. The result registers update at that same final edge. The bench drives inputs and samples outputs on falling edges. It waits for `done`, reads the pulses and result bytes in that cycle, and compares the operation log kept by its engine model against a list it builds from the requirements. The engine model adds a programmable acknowledge delay so that the hold behaviour is exercised.

// File: rtl/smbd_pkg.sv
package smbd_pkg;
  localparam int BYTE_W = 8;
  localparam int PROT_W = 3;
  localparam int IDX_W  = 3;

  localparam logic [PROT_W-1:0] P_QUICK  = 3'd0;
  localparam logic [PROT_W-1:0] P_BYTE   = 3'd1;
  localparam logic [PROT_W-1:0] P_BDATA  = 3'd2;
  localparam logic [PROT_W-1:0] P_WORD   = 3'd3;
  localparam logic [PROT_W-1:0] P_BLKDAT = 3'd5;
  localparam logic [PROT_W-1:0] P_I2CBLK = 3'd6;

  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_SEND = 3'd1, OP_RECV_ACK = 3'd2,
    OP_RECV_NACK = 3'd3, OP_STOP = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_ADDR_W, SRC_ADDR_R, SRC_ADDR_RW, SRC_CMD, SRC_D0, SRC_D1
  } src_e;

  typedef enum logic [1:0] { DST_NONE, DST_D0, DST_D1, DST_BLK } dst_e;

  typedef struct packed {
    op_e  code;
    src_e src;
    dst_e dst;
    logic last;
  } step_t;

  function automatic step_t mk(op_e c, src_e s, dst_e d, logic l);
    step_t r;
    r.code = c; r.src = s; r.dst = d; r.last = l;
    return r;
  endfunction

  // Bus-running protocols; the others end at acceptance.
  function automatic logic runs_bus(logic [PROT_W-1:0] p);
    return (p == P_QUICK) || (p == P_BYTE) || (p == P_BDATA) ||
           (p == P_WORD) || (p == P_I2CBLK);
  endfunction

  // Operation number idx of protocol p in direction rd.
  function automatic step_t seq_step(logic [PROT_W-1:0] p, logic rd,
                                     logic [IDX_W-1:0] idx);
    step_t stp;
    stp = mk(OP_STOP, SRC_NONE, DST_NONE, 1'b1);
    case (p)
      P_QUICK:
        if (idx == 3'd0) stp = mk(OP_START, SRC_ADDR_RW, DST_NONE, 1'b0);
      P_BYTE:
        if (rd) begin
          case (idx)
            3'd0: stp = mk(OP_START, SRC_ADDR_R, DST_NONE, 1'b0);
            3'd1: stp = mk(OP_RECV_NACK, SRC_NONE, DST_D0, 1'b0);
            default: ;
          endcase
        end else begin
          case (idx)
            3'd0: stp = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
            3'd1: stp = mk(OP_SEND, SRC_CMD, DST_NONE, 1'b0);
            default: ;
          endcase
        end
      P_BDATA, P_WORD:
        if (rd) begin
          case (idx)
            3'd0: stp = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
            3'd1: stp = mk(OP_SEND, SRC_CMD, DST_NONE, 1'b0);
            3'd2: stp = mk(OP_START, SRC_ADDR_R, DST_NONE, 1'b0);
            3'd3: stp = (p == P_WORD) ? mk(OP_RECV_ACK, SRC_NONE, DST_D0, 1'b0)
                                      : mk(OP_RECV_NACK, SRC_NONE, DST_D0, 1'b0);
            3'd4: if (p == P_WORD) stp = mk(OP_RECV_NACK, SRC_NONE, DST_D1, 1'b0);
            default: ;
          endcase
        end else begin
          case (idx)
            3'd0: stp = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
            3'd1: stp = mk(OP_SEND, SRC_CMD, DST_NONE, 1'b0);
            3'd2: stp = mk(OP_SEND, SRC_D0, DST_NONE, 1'b0);
            3'd3: if (p == P_WORD) stp = mk(OP_SEND, SRC_D1, DST_NONE, 1'b0);
            default: ;
          endcase
        end
      P_I2CBLK:
        case (idx)
          3'd0: stp = mk(OP_START, SRC_ADDR_W, DST_NONE, 1'b0);
          3'd1: stp = mk(OP_SEND, SRC_D1, DST_NONE, 1'b0);
          3'd2: stp = mk(OP_START, SRC_ADDR_R, DST_NONE, 1'b0);
          default: stp = mk(OP_RECV_ACK, SRC_NONE, DST_BLK, 1'b1);
        endcase
      default: ;
    endcase
    return stp;
  endfunction
endpackage

// File: rtl/smbd_seq.sv
module smbd_seq
  import smbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              err_sticky,
  input  logic [PROT_W-1:0] proto_in,
  input  logic              rd_in,
  input  logic              op_ack,
  input  logic              op_err,
  output logic              busy,
  output logic              ev_accept,
  output logic              ev_fire,
  output step_t             cur_step,
  output logic [PROT_W-1:0] proto_q,
  output logic              fin_ok,
  output logic              fin_err,
  output logic              fin_blk
);
  logic             rd_q;
  logic [IDX_W-1:0] idx_q;

  assign ev_accept = start && !busy;
  assign ev_fire   = busy && op_ack;
  assign cur_step  = seq_step(proto_q, rd_q, idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx_q <= '0; proto_q <= '0; rd_q <= 1'b0;
      fin_ok <= 1'b0; fin_err <= 1'b0; fin_blk <= 1'b0;
    end else begin
      fin_ok <= 1'b0; fin_err <= 1'b0; fin_blk <= 1'b0;
      if (ev_accept) begin
        proto_q <= proto_in;
        rd_q    <= rd_in;
        idx_q   <= '0;
        if (err_sticky)              fin_err <= 1'b1;
        else if (proto_in == P_BLKDAT) fin_blk <= 1'b1;
        else if (!runs_bus(proto_in))  fin_err <= 1'b1;
        else                           busy    <= 1'b1;
      end else if (ev_fire) begin
        if (op_err) begin
          busy <= 1'b0; fin_err <= 1'b1;
        end else if (cur_step.last) begin
          busy <= 1'b0; fin_ok <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_FIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_ok, fin_err, fin_blk}));  // R8
  AST_ERR_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && op_err) |=> (!busy && fin_err && !fin_ok));  // R9
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !op_ack) |=> (busy && $stable(proto_q) && $stable(idx_q)));  // R12
endmodule

// File: rtl/smbd_capture.sv
module smbd_capture
  import smbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              ev_fire,
  input  logic              op_err,
  input  step_t             cur_step,
  input  logic [BYTE_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] cmd_in,
  input  logic [BYTE_W-1:0] data0_in,
  input  logic [BYTE_W-1:0] data1_in,
  input  logic [BYTE_W-1:0] op_rdata,
  output logic [BYTE_W-1:0] op_byte,
  output logic [BYTE_W-1:0] rd_data0,
  output logic [BYTE_W-1:0] rd_data1,
  output logic [BYTE_W-1:0] blk_byte
);
  logic [BYTE_W-1:0] addr_q, cmd_q, d0_q, d1_q;
  logic              cap_fire;

  assign cap_fire = ev_fire && !op_err && (cur_step.dst != DST_NONE);

  always_comb begin
    case (cur_step.src)
      SRC_ADDR_W:  op_byte = {addr_q[BYTE_W-1:1], 1'b0};
      SRC_ADDR_R:  op_byte = {addr_q[BYTE_W-1:1], 1'b1};
      SRC_ADDR_RW: op_byte = addr_q;
      SRC_CMD:     op_byte = cmd_q;
      SRC_D0:      op_byte = d0_q;
      SRC_D1:      op_byte = d1_q;
      default:     op_byte = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0; cmd_q <= '0; d0_q <= '0; d1_q <= '0;
      rd_data0 <= '0; rd_data1 <= '0; blk_byte <= '0;
    end else begin
      if (ev_accept) begin
        addr_q <= addr_in; cmd_q <= cmd_in; d0_q <= data0_in; d1_q <= data1_in;
      end
      if (cap_fire) begin
        case (cur_step.dst)
          DST_D0:  rd_data0 <= op_rdata;
          DST_D1:  rd_data1 <= op_rdata;
          default: blk_byte <= op_rdata;
        endcase
      end
    end
  end

  AST_CAPTURE_ON_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> (cur_step.code == OP_RECV_ACK || cur_step.code == OP_RECV_NACK));  // R6
endmodule

// File: rtl/smbus_xact_dispatch.sv
module smbus_xact_dispatch
  import smbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PROT_W-1:0] ctl_proto,
  input  logic [BYTE_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] cmd_in,
  input  logic [BYTE_W-1:0] data0_in,
  input  logic [BYTE_W-1:0] data1_in,
  input  logic              err_sticky,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic [BYTE_W-1:0] op_byte,
  input  logic              op_ack,
  input  logic              op_err,
  input  logic [BYTE_W-1:0] op_rdata,
  output logic              busy,
  output logic              done,
  output logic              intr_set,
  output logic              dev_err_set,
  output logic              blk_go,
  output logic              blkrd_ready,
  output logic [BYTE_W-1:0] rd_data0,
  output logic [BYTE_W-1:0] rd_data1,
  output logic [BYTE_W-1:0] blk_byte
);
  step_t             cur_step;
  logic              ev_accept, ev_fire, fin_ok, fin_err, fin_blk;
  logic [PROT_W-1:0] proto_q;

  smbd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .err_sticky(err_sticky),
    .proto_in(ctl_proto), .rd_in(addr_in[0]), .op_ack(op_ack), .op_err(op_err),
    .busy(busy), .ev_accept(ev_accept), .ev_fire(ev_fire), .cur_step(cur_step),
    .proto_q(proto_q), .fin_ok(fin_ok), .fin_err(fin_err), .fin_blk(fin_blk)
  );

  smbd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .ev_accept(ev_accept), .ev_fire(ev_fire),
    .op_err(op_err), .cur_step(cur_step), .addr_in(addr_in), .cmd_in(cmd_in),
    .data0_in(data0_in), .data1_in(data1_in), .op_rdata(op_rdata),
    .op_byte(op_byte), .rd_data0(rd_data0), .rd_data1(rd_data1),
    .blk_byte(blk_byte)
  );

  assign op_valid    = busy;
  assign op_code     = cur_step.code;
  assign intr_set    = fin_ok && (proto_q != P_I2CBLK);
  assign blkrd_ready = fin_ok && (proto_q == P_I2CBLK);
  assign dev_err_set = fin_err;
  assign blk_go      = fin_blk;
  assign done        = fin_ok || fin_err || fin_blk;

  AST_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ack) |=> (op_valid && $stable(op_code) && $stable(op_byte)));  // R13
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({intr_set, dev_err_set, blk_go, blkrd_ready}));  // R3
  AST_HANDOFF_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    blk_go |-> !op_valid);  // R11
  AST_BLKRD_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    blkrd_ready |=> $stable(blk_byte));  // R7
endmodule

// File: tb/test_smbus_xact_dispatch.sv
module test_smbus_xact_dispatch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, err_sticky = 1'b0;
  logic [2:0] ctl_proto = '0;
  logic [7:0] addr_in = '0, cmd_in = '0, data0_in = '0, data1_in = '0;
  logic op_valid, op_ack = 1'b0, op_err = 1'b0;
  logic [2:0] op_code;
  logic [7:0] op_byte, op_rdata = '0;
  logic busy, done, intr_set, dev_err_set, blk_go, blkrd_ready;
  logic [7:0] rd_data0, rd_data1, blk_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_xact_dispatch i_smbus_xact_dispatch (.*);

  int checks = 0, errors = 0;
  // engine model state
  logic [10:0] log_ops [0:15];
  int log_n = 0, fail_at = -1, lat = 0, wait_cnt = 0, hold_bad = 0;
  logic [7:0] rx_val = '0;
  logic [10:0] held;
  logic [10:0] exp_ops [0:15];
  int exp_n = 0;
  logic r_intr, r_err, r_blk, r_blkrd;

  always @(negedge clk) begin
    if (!rst_n) begin
      op_ack = 1'b0; wait_cnt = 0;
    end else if (op_ack) begin
      op_ack = 1'b0; op_err = 1'b0; wait_cnt = 0;
    end else if (op_valid) begin
      if (wait_cnt == 0) held = {op_code, op_byte};
      else if (held != {op_code, op_byte}) hold_bad++;
      if (wait_cnt >= lat) begin
        if (log_n < 16) log_ops[log_n] = {op_code, op_byte};
        op_err = (log_n == fail_at);
        log_n++;
        if (op_code == 3'd2 || op_code == 3'd3) begin
          op_rdata = rx_val; rx_val = rx_val + 8'd1;
        end
        op_ack = 1'b1;
      end else wait_cnt++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] enc(logic [2:0] c, logic [7:0] b);
    return {c, b};
  endfunction

  task automatic expect_op(logic [2:0] c, logic [7:0] b);
    exp_ops[exp_n] = enc(c, b); exp_n++;
  endtask

  // launch one transaction and wait for done
  task automatic run(logic [2:0] p, logic [7:0] a, logic [7:0] c, logic [7:0] d0,
                     logic [7:0] d1, logic stk, int fa, logic [7:0] rxb, int l);
    @(negedge clk);
    log_n = 0; exp_n = 0; fail_at = fa; rx_val = rxb; lat = l; hold_bad = 0;
    ctl_proto = p; addr_in = a; cmd_in = c; data0_in = d0; data1_in = d1;
    err_sticky = stk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    r_intr = intr_set; r_err = dev_err_set; r_blk = blk_go; r_blkrd = blkrd_ready;
    err_sticky = 1'b0;
  endtask

  task automatic cmp_ops(string req);
    chk({req, " op count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk({req, " op"}, log_ops[i], exp_ops[i]);
  endtask

  task automatic t_quick;
    run(3'd0, 8'hA1, 8'h00, 8'h00, 8'h00, 0, -1, 8'h00, 0);
    expect_op(0, 8'hA1); expect_op(4, 8'h00);
    cmp_ops("R3 quick rd"); chk("R3 intr", r_intr, 1);
    run(3'd0, 8'hA0, 8'h00, 8'h00, 8'h00, 0, -1, 8'h00, 0);
    expect_op(0, 8'hA0); expect_op(4, 8'h00);
    cmp_ops("R2 quick wr");
  endtask

  task automatic t_byte;
    run(3'd1, 8'h5A, 8'h3C, 8'h00, 8'h00, 0, -1, 8'h00, 1);
    expect_op(0, 8'h5A); expect_op(1, 8'h3C); expect_op(4, 8'h00);
    cmp_ops("R4 byte wr"); chk("R4 intr", r_intr, 1);
    run(3'd1, 8'h5B, 8'h3C, 8'h00, 8'h00, 0, -1, 8'h77, 0);
    expect_op(0, 8'h5B); expect_op(3, 8'h00); expect_op(4, 8'h00);
    cmp_ops("R4 byte rd"); chk("R4 data0", rd_data0, 8'h77);
  endtask

  task automatic t_bdata;
    run(3'd2, 8'h30, 8'h11, 8'h22, 8'h00, 0, -1, 8'h00, 0);
    expect_op(0, 8'h30); expect_op(1, 8'h11); expect_op(1, 8'h22); expect_op(4, 8'h00);
    cmp_ops("R5 bdata wr"); chk("R5 intr", r_intr, 1);
    run(3'd2, 8'h31, 8'h12, 8'h00, 8'h00, 0, -1, 8'h9C, 0);
    expect_op(0, 8'h30); expect_op(1, 8'h12); expect_op(0, 8'h31);
    expect_op(3, 8'h00); expect_op(4, 8'h00);
    cmp_ops("R5 bdata rd"); chk("R5 data0", rd_data0, 8'h9C);
  endtask

  task automatic t_word;
    run(3'd3, 8'h40, 8'h05, 8'hCD, 8'hAB, 0, -1, 8'h00, 2);
    expect_op(0, 8'h40); expect_op(1, 8'h05); expect_op(1, 8'hCD);
    expect_op(1, 8'hAB); expect_op(4, 8'h00);
    cmp_ops("R6 word wr"); chk("R13 hold", hold_bad, 0);
    run(3'd3, 8'h41, 8'h06, 8'h00, 8'h00, 0, -1, 8'h34, 0);
    expect_op(0, 8'h40); expect_op(1, 8'h06); expect_op(0, 8'h41);
    expect_op(2, 8'h00); expect_op(3, 8'h00); expect_op(4, 8'h00);
    cmp_ops("R6 word rd");
    chk("R6 low", rd_data0, 8'h34); chk("R6 high", rd_data1, 8'h35);
    chk("R6 intr", r_intr, 1);
  endtask

  task automatic t_i2cblk;
    run(3'd6, 8'h51, 8'h00, 8'h00, 8'h2E, 0, -1, 8'hE1, 0);
    expect_op(0, 8'h50); expect_op(1, 8'h2E); expect_op(0, 8'h51); expect_op(2, 8'h00);
    cmp_ops("R7 i2c blk");
    chk("R7 blk byte", blk_byte, 8'hE1); chk("R7 ready", r_blkrd, 1);
    chk("R7 no intr", r_intr, 0);
  endtask

  task automatic t_refused;
    run(3'd4, 8'h20, 8'h00, 8'h00, 8'h00, 0, -1, 8'h00, 0);
    chk("R8 proto4 ops", log_n, 0); chk("R8 proto4 err", r_err, 1);
    run(3'd7, 8'h20, 8'h00, 8'h00, 8'h00, 0, -1, 8'h00, 0);
    chk("R8 proto7 ops", log_n, 0); chk("R8 proto7 err", r_err, 1);
    run(3'd3, 8'h21, 8'h00, 8'h00, 8'h00, 1, -1, 8'h00, 0);
    chk("R10 sticky ops", log_n, 0); chk("R10 sticky err", r_err, 1);
    chk("R10 no intr", r_intr, 0);
    run(3'd5, 8'h21, 8'h00, 8'h00, 8'h00, 0, -1, 8'h00, 0);
    chk("R11 ops", log_n, 0); chk("R11 blk_go", r_blk, 1); chk("R11 no intr", r_intr, 0);
  endtask

  task automatic t_fail;
    run(3'd3, 8'h60, 8'h01, 8'h02, 8'h03, 0, 1, 8'h00, 0);
    repeat (4) @(negedge clk);
    chk("R9 ops", log_n, 2); chk("R9 err", r_err, 1); chk("R9 no intr", r_intr, 0);
    chk("R9 idle", busy, 0);
  endtask

  task automatic t_busy_start;
    @(negedge clk);
    log_n = 0; exp_n = 0; fail_at = -1; rx_val = 8'h70; lat = 1;
    ctl_proto = 3'd3; addr_in = 8'h41; cmd_in = 8'h09; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    ctl_proto = 3'd0; addr_in = 8'h10; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    r_intr = intr_set;
    repeat (6) @(negedge clk);
    expect_op(0, 8'h40); expect_op(1, 8'h09); expect_op(0, 8'h41);
    expect_op(2, 8'h00); expect_op(3, 8'h00); expect_op(4, 8'h00);
    cmp_ops("R12 ignored start");
    chk("R12 data0", rd_data0, 8'h70); chk("R12 idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 op_valid", op_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 data", {rd_data0, rd_data1, blk_byte}, 0);
    rst_n = 1'b1;
    t_quick; t_byte; t_bdata; t_word; t_i2cblk; t_refused; t_fail; t_busy_start;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule